// File: doc/BRIEF.md
# Five-Stage In-Order Processor Pipeline

This block is a small in-order processor pipeline with five stages: fetch, decode, execute, memory and writeback. It runs direct and register-indirect loads and stores, a conditional jump, jump-and-link, a conditional jump through a register, move, add, increment and compare. Memory lives outside the block. It offers one read port for instruction fetch, a second read port for data, and one write port. Both read ports answer combinationally within the same cycle. The register file sits inside the block and has two read ports and one write port.

Every stage keeps its own copy of the instruction fields. Values move between stages only through named transfer registers:

- an address register and a store-data register, both loaded in execute;
- a load-data register, loaded in memory;
- a two-register relay for ALU results;
- a two-register chain for the link value of jump-and-link.

The next program counter comes from a multiplexer. It picks the jump target when a jump in execute is taken, holds during a stall, and otherwise steps by one. There is no forwarding. When decode needs a register that an older instruction has not yet written back, decode waits. The register file passes a same-cycle write straight through to its read ports. The memory ports are plain single-cycle ports with no back-pressure, so the pipeline never waits on memory.

Top module: `p5_pipe`

## Requirements
- R1: While rst_n is low, fetch_addr is 0 and neither data_we nor data_re is high. The instruction at address 0 enters decode on the first rising edge after reset.
- R2: An instruction word is {op[3:0], ra[RW-1:0], rb[RW-1:0], ads[AW-1:0]}, most significant field first. Op 1 (load) reads the word at address ads into register ra. Op 2 (store) writes register ra to address ads.
- R3: Op 9 (add) writes ra+rb, truncated to DW bits, into ra. It sets the condition flag to 1 exactly when that result is zero.
- R4: Op 8 (move) copies register ra into register rb. Op 10 (increment) writes ra+1 into ra.
- R5: Op 3 (indirect load) reads the word at the address held in ra into rb. Op 4 (indirect store) writes ra to the address held in rb.
- R6: Op 5 (conditional jump) goes to ads when the condition flag is 1. When it is taken, the two instructions fetched after it have no effect. When it is not taken, they execute.
- R7: Op 6 (jump-and-link) always goes to ads and writes the jump's own address plus 1 into ra.
- R8: Op 7 (register jump) goes to the address held in ra when the condition flag is 1. A taken register jump cancels the two following instructions, as in R6.
- R9: Decode holds an instruction while its source register is the destination of an instruction in execute or in memory. A store placed directly after an add that itself waited one cycle on a load gives a specific timing: with loads at addresses 0..2, the add at 3 and the store at 4, the store's memory write is seen on the 11th rising edge after reset.
- R10: Op 11 (compare) sets the condition flag to 1 exactly when ra equals rb. Only add and compare change the flag.
- R11: When a taken jump in execute and a decode stall fall in the same cycle, the jump wins. The pipeline goes to the target and the stalled instruction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_addr | output | AW | Instruction fetch address (the program counter) |
| fetch_instr | input | IW | Instruction word at fetch_addr, same cycle |
| data_re | output | 1 | High while a load in the memory stage reads data |
| data_raddr | output | AW | Data read address |
| data_rdata | input | DW | Data word at data_raddr, same cycle |
| data_we | output | 1 | Data write strobe, taken at the next rising edge |
| data_waddr | output | AW | Data write address |
| data_wdata | output | DW | Data write value |

## Verification
Two functions can meet in one cycle: a taken jump in execute, and a decode stall on a register that the jump itself produces. A jump-and-link is followed directly by an increment of its own link register, so the stall and the flush fire together. The bench then checks that only the target's store lands, and that it carries the link value. A second collision covers a flush whose flag was set by the compare just ahead of it. A sweep over pairs of operands makes the compare come out both ways, and also makes the add result zero or non-zero. The expected memory image and the exact count of memory writes are derived from those operands.

// File: rtl/p5_pkg.sv
package p5_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_LD  = 4'd1,
    OP_ST  = 4'd2,
    OP_LDR = 4'd3,
    OP_STR = 4'd4,
    OP_JMP = 4'd5,
    OP_JAL = 4'd6,
    OP_JR  = 4'd7,
    OP_MOV = 4'd8,
    OP_ADD = 4'd9,
    OP_INC = 4'd10,
    OP_CMP = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_LOAD = 2'd1,
    WB_LINK = 2'd2
  } wb_src_e;

  function automatic logic op_writes(op_e op);
    return op inside {OP_LD, OP_LDR, OP_JAL, OP_MOV, OP_ADD, OP_INC};
  endfunction

  function automatic logic op_dst_is_rb(op_e op);
    return op inside {OP_LDR, OP_MOV};
  endfunction

  function automatic logic op_reads_ra(op_e op);
    return op inside {OP_ST, OP_LDR, OP_STR, OP_JR, OP_MOV, OP_ADD, OP_INC, OP_CMP};
  endfunction

  function automatic logic op_reads_rb(op_e op);
    return op inside {OP_STR, OP_ADD, OP_CMP};
  endfunction

  function automatic logic op_is_load(op_e op);
    return op inside {OP_LD, OP_LDR};
  endfunction

  function automatic logic op_is_store(op_e op);
    return op inside {OP_ST, OP_STR};
  endfunction

  function automatic wb_src_e op_wb_src(op_e op);
    if (op_is_load(op)) return WB_LOAD;
    if (op == OP_JAL)   return WB_LINK;
    return WB_ALU;
  endfunction

endpackage

// File: rtl/p5_regfile.sv
module p5_regfile #(
  parameter int DW = 16,
  parameter int RN = 8,
  localparam int RW = $clog2(RN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ra_a,
  input  logic [RW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [RW-1:0] wa,
  input  logic [DW-1:0] wd
);

  logic [DW-1:0] regs [RN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RN; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  // a write in the same cycle is passed straight to the read ports
  assign rd_a = (we && wa == ra_a) ? wd : regs[ra_a];
  assign rd_b = (we && wa == ra_b) ? wd : regs[ra_b];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs[$past(wa)] == $past(wd))); // R3

endmodule

// File: rtl/p5_hazard.sv
module p5_hazard #(
  parameter int RW = 3
) (
  input  logic          d_v,
  input  p5_pkg::op_e   d_op,
  input  logic [RW-1:0] d_ra,
  input  logic [RW-1:0] d_rb,
  input  logic          x_wr,
  input  logic [RW-1:0] x_dst,
  input  logic          m_wr,
  input  logic [RW-1:0] m_dst,
  output logic          stall
);
  import p5_pkg::*;

  logic hit_a, hit_b;

  assign hit_a = op_reads_ra(d_op) &&
                 ((x_wr && x_dst == d_ra) || (m_wr && m_dst == d_ra));
  assign hit_b = op_reads_rb(d_op) &&
                 ((x_wr && x_dst == d_rb) || (m_wr && m_dst == d_rb));
  assign stall = d_v && (hit_a || hit_b);

endmodule

// File: rtl/p5_exec.sv
module p5_exec #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  p5_pkg::op_e   op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [AW-1:0] ads,
  input  logic          cc_in,
  output logic [DW-1:0] res,
  output logic [AW-1:0] mar,
  output logic          jump,
  output logic [AW-1:0] target,
  output logic          cc_we,
  output logic          cc_val
);
  import p5_pkg::*;

  logic [DW-1:0] sum;
  assign sum = a + b;

  always_comb begin
    res    = a;
    mar    = ads;
    jump   = 1'b0;
    target = ads;
    cc_we  = 1'b0;
    cc_val = cc_in;
    case (op)
      OP_LDR: mar = AW'(a);
      OP_STR: mar = AW'(b);
      OP_JMP: jump = cc_in;
      OP_JAL: jump = 1'b1;
      OP_JR: begin
        jump   = cc_in;
        target = AW'(a);
      end
      OP_ADD: begin
        res    = sum;
        cc_we  = 1'b1;
        cc_val = (sum == '0);
      end
      OP_INC: res = a + DW'(1);
      OP_CMP: begin
        cc_we  = 1'b1;
        cc_val = (a == b);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/p5_pipe.sv
module p5_pipe #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int RN = 8,
  localparam int RW = $clog2(RN),
  localparam int IW = 4 + 2 * RW + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] fetch_addr,
  input  logic [IW-1:0] fetch_instr,
  output logic          data_re,
  output logic [AW-1:0] data_raddr,
  input  logic [DW-1:0] data_rdata,
  output logic          data_we,
  output logic [AW-1:0] data_waddr,
  output logic [DW-1:0] data_wdata
);
  import p5_pkg::*;

  // fetch
  logic [AW-1:0] pc_q, pc_inc;
  // decode
  logic          d_v;
  logic [IW-1:0] d_ir;
  logic [AW-1:0] d_pc1;
  op_e           d_op;
  logic [RW-1:0] d_ra, d_rb;
  logic [DW-1:0] d_a, d_b;
  // execute
  logic          x_v;
  op_e           x_op;
  logic [RW-1:0] x_ra, x_rb, x_dst;
  logic [AW-1:0] x_ads, x_pc1;
  logic [DW-1:0] x_a, x_b;
  logic          x_wr;
  logic [DW-1:0] ex_res;
  logic [AW-1:0] ex_mar, ex_target;
  logic          ex_jump, ex_cc_we, ex_cc_val, taken;
  logic          cc_q;
  // memory
  logic          m_v, m_wr;
  op_e           m_op;
  logic [RW-1:0] m_dst;
  logic [AW-1:0] m_mar, m_link;
  logic [DW-1:0] m_smdr, m_t;
  // writeback
  logic          w_wr;
  wb_src_e       w_src;
  logic [RW-1:0] w_dst;
  logic [DW-1:0] w_lmdr, w_t1, w_data;
  logic [AW-1:0] w_link;

  logic stall;

  assign pc_inc     = pc_q + AW'(1);
  assign fetch_addr = pc_q;

  assign d_op = op_e'(d_ir[IW-1 -: 4]);
  assign d_ra = d_ir[AW+2*RW-1 -: RW];
  assign d_rb = d_ir[AW+RW-1 -: RW];

  p5_regfile #(.DW(DW), .RN(RN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(d_ra), .ra_b(d_rb), .rd_a(d_a), .rd_b(d_b),
    .we(w_wr), .wa(w_dst), .wd(w_data)
  );

  assign x_wr  = x_v && op_writes(x_op);
  assign x_dst = op_dst_is_rb(x_op) ? x_rb : x_ra;

  p5_hazard #(.RW(RW)) u_hz (
    .d_v(d_v), .d_op(d_op), .d_ra(d_ra), .d_rb(d_rb),
    .x_wr(x_wr), .x_dst(x_dst), .m_wr(m_wr), .m_dst(m_dst),
    .stall(stall)
  );

  p5_exec #(.DW(DW), .AW(AW)) u_ex (
    .op(x_op), .a(x_a), .b(x_b), .ads(x_ads), .cc_in(cc_q),
    .res(ex_res), .mar(ex_mar), .jump(ex_jump), .target(ex_target),
    .cc_we(ex_cc_we), .cc_val(ex_cc_val)
  );

  assign taken = x_v && ex_jump;

  // front: PC select, decode latch, issue into execute
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      d_v   <= 1'b0;
      d_ir  <= '0;
      d_pc1 <= '0;
      x_v   <= 1'b0;
      x_op  <= OP_NOP;
      x_ra  <= '0;
      x_rb  <= '0;
      x_ads <= '0;
      x_pc1 <= '0;
      x_a   <= '0;
      x_b   <= '0;
      cc_q  <= 1'b0;
    end else begin
      if (taken) begin
        pc_q <= ex_target;
        d_v  <= 1'b0;
      end else if (!stall) begin
        pc_q  <= pc_inc;
        d_v   <= 1'b1;
        d_ir  <= fetch_instr;
        d_pc1 <= pc_inc;
      end
      x_v   <= d_v && !stall && !taken;
      x_op  <= d_op;
      x_ra  <= d_ra;
      x_rb  <= d_rb;
      x_ads <= d_ir[AW-1:0];
      x_pc1 <= d_pc1;
      x_a   <= d_a;
      x_b   <= d_b;
      if (x_v && ex_cc_we) cc_q <= ex_cc_val;
    end
  end

  // back: memory and writeback transfer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v    <= 1'b0;
      m_wr   <= 1'b0;
      m_op   <= OP_NOP;
      m_dst  <= '0;
      m_mar  <= '0;
      m_smdr <= '0;
      m_t    <= '0;
      m_link <= '0;
      w_wr   <= 1'b0;
      w_src  <= WB_ALU;
      w_dst  <= '0;
      w_lmdr <= '0;
      w_t1   <= '0;
      w_link <= '0;
    end else begin
      m_v    <= x_v;
      m_wr   <= x_wr;
      m_op   <= x_op;
      m_dst  <= x_dst;
      m_mar  <= ex_mar;
      m_smdr <= x_a;
      m_t    <= ex_res;
      m_link <= x_pc1;
      w_wr   <= m_wr;
      w_src  <= op_wb_src(m_op);
      w_dst  <= m_dst;
      w_lmdr <= data_rdata;
      w_t1   <= m_t;
      w_link <= m_link;
    end
  end

  assign data_re    = m_v && op_is_load(m_op);
  assign data_raddr = m_mar;
  assign data_we    = m_v && op_is_store(m_op);
  assign data_waddr = m_mar;
  assign data_wdata = m_smdr;

  always_comb begin
    case (w_src)
      WB_LOAD: w_data = w_lmdr;
      WB_LINK: w_data = DW'(w_link);
      default: w_data = w_t1;
    endcase
  end

  AST_FLUSH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (!d_v && !x_v)); // R6
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (pc_q == $past(ex_target))); // R8
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !taken) |=> ($stable(pc_q) && $stable(d_ir) && !x_v)); // R9
  AST_JUMP_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && taken) |=> (!d_v && pc_q == $past(ex_target))); // R11

endmodule

// File: tb/sim_p5_pipe.sv
module sim_p5_pipe;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int RN = 8;
  localparam int IW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_addr;
  logic [IW-1:0] fetch_instr;
  logic          data_re, data_we;
  logic [AW-1:0] data_raddr, data_waddr;
  logic [DW-1:0] data_rdata, data_wdata;

  logic [IW-1:0] imem [256];
  logic [DW-1:0] dmem [256];
  logic [DW-1:0] cur_a = '0, cur_b = '0;
  int cyc, wr_count, first_wr;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  p5_pipe #(.DW(DW), .AW(AW), .RN(RN)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_addr(fetch_addr), .fetch_instr(fetch_instr),
    .data_re(data_re), .data_raddr(data_raddr), .data_rdata(data_rdata),
    .data_we(data_we), .data_waddr(data_waddr), .data_wdata(data_wdata)
  );

  assign fetch_instr = imem[fetch_addr];
  assign data_rdata  = dmem[data_raddr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) dmem[i] <= '0;
      dmem[8'h10] <= cur_a;
      dmem[8'h11] <= cur_b;
      dmem[8'h12] <= 16'h0011;
      dmem[8'h13] <= 16'h0024;
      dmem[8'h14] <= 16'd30;
      cyc      <= 0;
      wr_count <= 0;
      first_wr <= -1;
    end else begin
      cyc <= cyc + 1;
      if (data_we) begin
        dmem[data_waddr] <= data_wdata;
        wr_count <= wr_count + 1;
        if (first_wr < 0) first_wr <= cyc;
      end
    end
  end

  function automatic logic [IW-1:0] ins(input int op, input int ra, input int rb, input int ads);
    return {4'(op), 3'(ra), 3'(rb), 8'(ads)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] e22, e25, twob;
    rst_n = 1'b0;
    cur_a = a;
    cur_b = b;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 fetch_addr in reset", int'(fetch_addr), 0);
    check("R1 strobes in reset", int'({data_we, data_re}), 0);
    rst_n = 1'b1;
    repeat (150) @(negedge clk);
    e22  = (a == b) ? a : DW'(a + 16'd2);
    twob = DW'(b + b);
    e25  = (twob == '0) ? twob : DW'(twob + 16'd2);
    check("R2/R3 add of loaded words", int'(dmem[8'h20]), int'(DW'(a + b)));
    check("R4 move then increment", int'(dmem[8'h21]), int'(DW'(b + 16'd1)));
    check("R6/R10 compare and conditional jump", int'(dmem[8'h22]), int'(e22));
    check("R7/R11 link value with stall at jump", int'(dmem[8'h23]), 14);
    check("R5 indirect load and store", int'(dmem[8'h24]), int'(b));
    check("R8/R3 register jump on add flag", int'(dmem[8'h25]), int'(e25));
    check("R6 flushed stores never write", wr_count, 6);
    check("R9 stall timing of first store", first_wr, 10);
  endtask

  initial begin
    logic [DW-1:0] vals [6];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002;
    vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h1234;
    for (int i = 0; i < 256; i++) imem[i] = '0;
    imem[0]  = ins(1, 1, 0, 'h10);
    imem[1]  = ins(1, 2, 0, 'h11);
    imem[2]  = ins(1, 4, 0, 'h10);
    imem[3]  = ins(9, 1, 2, 0);
    imem[4]  = ins(2, 1, 0, 'h20);
    imem[5]  = ins(8, 2, 3, 0);
    imem[6]  = ins(10, 3, 0, 0);
    imem[7]  = ins(2, 3, 0, 'h21);
    imem[8]  = ins(11, 4, 2, 0);
    imem[9]  = ins(5, 0, 0, 12);
    imem[10] = ins(10, 4, 0, 0);
    imem[11] = ins(10, 4, 0, 0);
    imem[12] = ins(2, 4, 0, 'h22);
    imem[13] = ins(6, 5, 0, 20);
    imem[14] = ins(10, 5, 0, 0);
    imem[15] = ins(10, 5, 0, 0);
    imem[20] = ins(2, 5, 0, 'h23);
    imem[21] = ins(1, 6, 0, 'h12);
    imem[22] = ins(3, 6, 7, 0);
    imem[23] = ins(1, 3, 0, 'h13);
    imem[24] = ins(4, 7, 3, 0);
    imem[25] = ins(9, 7, 7, 0);
    imem[26] = ins(1, 0, 0, 'h14);
    imem[27] = ins(7, 0, 0, 0);
    imem[28] = ins(10, 7, 0, 0);
    imem[29] = ins(10, 7, 0, 0);
    imem[30] = ins(2, 7, 0, 'h25);
    imem[31] = ins(11, 0, 0, 0);
    imem[32] = ins(5, 0, 0, 32);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        run_case(vals[i], vals[j]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

endmodule